// File: doc/BRIEF.md
# Matrix Profile Diagonal Walker

This unit builds the matrix profile of a short time series, one diagonal of the subsequence distance matrix at a time. A command names a range of diagonal offsets, the subsequence length `m` and the series length `n`. The unit works through the offsets in increasing order. For each offset `k` that is accepted, it forms the full dot product of the first subsequence pair `(0, k)`. It then moves down the diagonal and updates that dot product in constant time per cell. Every cell gives a squared z-normalised distance. That distance is folded into the profile entry of the row subsequence and into the entry of the column subsequence.

The series sits in a dual-read scratchpad that is loaded before the command. Each word holds one sample together with the mean and inverse deviation of the subsequence that starts at that address. Both read ports have a fixed latency of one cycle and no handshake. Profile improvements leave the unit as a valid/ready write stream. A word is transferred on a clock edge where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, the unit holds the word unchanged and stops all further work, so back-pressure costs cycles and never loses data. `done` pulses once when the batch is finished.

Top module: `mp_diag_unit`

## Requirements
- R1: After reset, `wr_valid` and `done` are low.
- R2: For the first cell of diagonal k (row 0, column k), the unit forms QT as the sum over t<m of s[t]·s[k+t]. It then computes d2 = 2·((m<<8) − (((QT − m·μ0·μk)·σ0·σk) >>> 8)) and clamps the result to the range 0 to 2^32−1. Scratchpad word bits [23:16] hold the signed sample s, bits [15:8] the signed mean μ and bits [7:0] the unsigned inverse deviation σ, with 8 fraction bits.
- R3: For each later cell (i+1, j+1) on a diagonal, QT is updated as QT − s[i]·s[j] + s[i+m]·s[j+m]. The distance must equal the value that a full dot product would give.
- R4: Each cell (i, j) first offers entry i with index j, then entry j with index i. A write is emitted only when d2 is strictly smaller than the stored entry.
- R5: At every accepted command, all profile entries are reset to 2^32−1. Results from an earlier batch have no effect on a new one.
- R6: A diagonal k produces no cell when k < max(1, m>>2) or k ≥ n−m+1.
- R7: Diagonals run from `diag_first` to `diag_last` in increasing order, and cells within a diagonal run in increasing row order.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr`, `wr_dist` and `wr_idx` stay stable. No write is dropped or duplicated.
- R9: `done` is a one-cycle pulse that follows the final accepted write of the batch. A `start` that arrives while a batch is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command pulse, sampled only when idle |
| cfg_m | input | 6 | Subsequence length m |
| cfg_n | input | 6 | Series length n |
| diag_first | input | 6 | First diagonal offset of the batch |
| diag_last | input | 6 | Last diagonal offset of the batch |
| rd_addr_a | output | 5 | Scratchpad read address, port A |
| rd_data_a | input | 24 | Port A word, one cycle after its address |
| rd_addr_b | output | 5 | Scratchpad read address, port B |
| rd_data_b | input | 24 | Port B word, one cycle after its address |
| wr_valid | output | 1 | Profile write offered |
| wr_ready | input | 1 | Consumer accepts the write |
| wr_addr | output | 5 | Profile entry being written |
| wr_dist | output | 32 | New squared distance for that entry |
| wr_idx | output | 5 | Nearest-match index for that entry |
| done | output | 1 | Batch finished pulse |

## Verification
The assertions check four things on every cycle. A stalled write word holds still. No write falls inside the trivial-match band or outside the subsequence range. No write carries the cleared maximum. `done` is a single pulse that never coincides with an offered write. Only the bench scenarios can show that the numbers are right and that the order of row and column writes across diagonals is right. To do this, the bench compares the stream against a model that recomputes every dot product from scratch. The bench scenarios also show that a second batch starts from a cleared profile, that a fully excluded batch stays silent, and that a mid-run command is ignored.

// File: rtl/mp_pkg.sv
package mp_pkg;
  parameter int SMP_W = 8;

  typedef struct packed {
    logic signed [SMP_W-1:0] smp;
    logic signed [SMP_W-1:0] mean;
    logic        [SMP_W-1:0] sinv;
  } mp_word_t;

  localparam int WORD_W = $bits(mp_word_t);

  typedef enum logic [3:0] {
    S_IDLE, S_DIAG, S_DOT_RQ, S_DOT_AC, S_MS_RQ, S_MS_AC, S_DIST,
    S_ROW, S_COL, S_WAIT, S_STEP, S_STEP_AC, S_DONE
  } mp_state_e;
endpackage

// File: rtl/mp_zdist.sv
module mp_zdist import mp_pkg::*; #(
  parameter int CW   = 6,
  parameter int PW   = 32,
  parameter int FRAC = 8,
  parameter int AC   = 48
) (
  input  logic signed [AC-1:0]    qt,
  input  logic        [CW-1:0]    m,
  input  logic signed [SMP_W-1:0] mu_a,
  input  logic signed [SMP_W-1:0] mu_b,
  input  logic        [SMP_W-1:0] si_a,
  input  logic        [SMP_W-1:0] si_b,
  output logic        [PW-1:0]    d2
);
  localparam logic signed [AC-1:0] DMAX = AC'({PW{1'b1}});

  logic signed [AC-1:0] m_s, mua_s, mub_s, sia_s, sib_s;
  logic signed [AC-1:0] diff, corr, raw;

  always_comb begin
    m_s   = signed'(AC'(m));
    mua_s = AC'(mu_a);
    mub_s = AC'(mu_b);
    sia_s = signed'(AC'(si_a));
    sib_s = signed'(AC'(si_b));
    diff  = qt - m_s * mua_s * mub_s;
    corr  = (diff * sia_s * sib_s) >>> FRAC;
    raw   = 2 * ((m_s <<< FRAC) - corr);
    if (raw < 0)          d2 = '0;
    else if (raw > DMAX)  d2 = '1;
    else                  d2 = raw[PW-1:0];
  end
endmodule

// File: rtl/mp_profile_store.sv
module mp_profile_store #(
  parameter int NMAX = 32,
  parameter int PW   = 32,
  localparam int AW  = $clog2(NMAX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          upd_en,
  input  logic [AW-1:0] upd_addr,
  input  logic [PW-1:0] upd_dist,
  input  logic [AW-1:0] look_addr,
  output logic [PW-1:0] look_dist
);
  logic [PW-1:0] prof [NMAX];

  for (genvar g = 0; g < NMAX; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n || clear)
        prof[g] <= '1;
      else if (upd_en && upd_addr == AW'(g))
        prof[g] <= upd_dist;
    end
  end

  assign look_dist = prof[look_addr];
endmodule

// File: rtl/mp_diag_unit.sv
module mp_diag_unit import mp_pkg::*; #(
  parameter int NMAX = 32,
  parameter int PW   = 32,
  parameter int FRAC = 8,
  parameter int AC   = 48,
  localparam int AW  = $clog2(NMAX),
  localparam int CW  = AW + 1,
  localparam int KW  = CW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CW-1:0]     cfg_m,
  input  logic [CW-1:0]     cfg_n,
  input  logic [CW-1:0]     diag_first,
  input  logic [CW-1:0]     diag_last,
  output logic [AW-1:0]     rd_addr_a,
  input  logic [WORD_W-1:0] rd_data_a,
  output logic [AW-1:0]     rd_addr_b,
  input  logic [WORD_W-1:0] rd_data_b,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [AW-1:0]     wr_addr,
  output logic [PW-1:0]     wr_dist,
  output logic [AW-1:0]     wr_idx,
  output logic              done
);
  mp_state_e st;
  logic [CW-1:0] m_q, n_q, i, j, t;
  logic [KW-1:0] k, last_q;
  logic signed [AC-1:0] qt;
  logic signed [SMP_W-1:0] mu_i, mu_j, ti, tj;
  logic [SMP_W-1:0] si_i, si_j;
  logic [PW-1:0] d2_q, d2_w, look_dist;
  logic col_ph;

  mp_word_t wa, wb;
  logic [CW-1:0] ns, thr;
  logic [AW-1:0] look_addr;
  logic improve, upd_en, clear;
  logic signed [AC-1:0] pab, ptt;

  always_comb begin
    wa   = mp_word_t'(rd_data_a);
    wb   = mp_word_t'(rd_data_b);
    ns   = n_q - m_q + CW'(1);
    thr  = ((m_q >> 2) == '0) ? CW'(1) : (m_q >> 2);
    pab  = AC'(wa.smp) * AC'(wb.smp);
    ptt  = AC'(ti) * AC'(tj);
    look_addr = (st == S_COL) ? j[AW-1:0] : i[AW-1:0];
    improve   = d2_q < look_dist;
    upd_en    = (st == S_ROW || st == S_COL) && improve;
    clear     = (st == S_IDLE) && start;
    case (st)
      S_DOT_RQ: begin rd_addr_a = AW'(i + t); rd_addr_b = AW'(j + t); end
      S_MS_RQ:  begin rd_addr_a = AW'(i);     rd_addr_b = AW'(j);     end
      default:  begin rd_addr_a = AW'(i + m_q); rd_addr_b = AW'(j + m_q); end
    endcase
  end

  mp_zdist #(.CW(CW), .PW(PW), .FRAC(FRAC), .AC(AC)) u_dist (
    .qt(qt), .m(m_q), .mu_a(mu_i), .mu_b(mu_j),
    .si_a(si_i), .si_b(si_j), .d2(d2_w)
  );

  mp_profile_store #(.NMAX(NMAX), .PW(PW)) u_prof (
    .clk(clk), .rst_n(rst_n), .clear(clear), .upd_en(upd_en),
    .upd_addr(look_addr), .upd_dist(d2_q),
    .look_addr(look_addr), .look_dist(look_dist)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      m_q <= '0; n_q <= '0; i <= '0; j <= '0; t <= '0;
      k <= '0; last_q <= '0; qt <= '0;
      mu_i <= '0; mu_j <= '0; ti <= '0; tj <= '0; si_i <= '0; si_j <= '0;
      d2_q <= '0; col_ph <= 1'b0;
      wr_valid <= 1'b0; wr_addr <= '0; wr_dist <= '0; wr_idx <= '0;
      done <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          done <= 1'b0;
          if (start) begin
            m_q <= cfg_m; n_q <= cfg_n;
            k <= KW'(diag_first); last_q <= KW'(diag_last);
            st <= S_DIAG;
          end
        end
        S_DIAG: begin
          if (k > last_q) st <= S_DONE;
          else if (k < KW'(thr) || k >= KW'(ns)) k <= k + KW'(1);
          else begin
            i <= '0; j <= k[CW-1:0]; t <= '0; qt <= '0;
            st <= S_DOT_RQ;
          end
        end
        S_DOT_RQ: st <= S_DOT_AC;
        S_DOT_AC: begin
          qt <= qt + pab;
          t  <= t + CW'(1);
          st <= (t + CW'(1) == m_q) ? S_MS_RQ : S_DOT_RQ;
        end
        S_MS_RQ: st <= S_MS_AC;
        S_MS_AC: begin
          mu_i <= wa.mean; si_i <= wa.sinv; ti <= wa.smp;
          mu_j <= wb.mean; si_j <= wb.sinv; tj <= wb.smp;
          st <= S_DIST;
        end
        S_DIST: begin d2_q <= d2_w; st <= S_ROW; end
        S_ROW: begin
          if (improve) begin
            wr_valid <= 1'b1; wr_addr <= i[AW-1:0];
            wr_dist <= d2_q; wr_idx <= j[AW-1:0];
            col_ph <= 1'b0; st <= S_WAIT;
          end else st <= S_COL;
        end
        S_COL: begin
          if (improve) begin
            wr_valid <= 1'b1; wr_addr <= j[AW-1:0];
            wr_dist <= d2_q; wr_idx <= i[AW-1:0];
            col_ph <= 1'b1; st <= S_WAIT;
          end else st <= S_STEP;
        end
        S_WAIT: begin
          if (wr_ready) begin
            wr_valid <= 1'b0;
            st <= col_ph ? S_STEP : S_COL;
          end
        end
        S_STEP: begin
          if (i + CW'(1) >= ns - k[CW-1:0]) begin
            k <= k + KW'(1); st <= S_DIAG;
          end else st <= S_STEP_AC;
        end
        S_STEP_AC: begin
          qt <= qt - ptt + pab;
          i <= i + CW'(1); j <= j + CW'(1);
          st <= S_MS_RQ;
        end
        S_DONE: begin done <= 1'b1; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [AW-1:0] wr_gap;
  assign wr_gap = (wr_addr > wr_idx) ? (wr_addr - wr_idx) : (wr_idx - wr_addr);

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_dist) && $stable(wr_idx)); // R8
  AST_EXCL_ZONE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> CW'(wr_gap) >= thr); // R6
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> CW'(wr_addr) < ns && CW'(wr_idx) < ns); // R4
  AST_NOT_CLEARED_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_dist != '1); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_valid); // R9
endmodule

// File: tb/mp_diag_unit_test.sv
module mp_diag_unit_test;
  import mp_pkg::*;
  localparam int NMAX = 32;
  localparam int AW = 5;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] cfg_m = '0, cfg_n = '0, diag_first = '0, diag_last = '0;
  logic [AW-1:0] rd_addr_a, rd_addr_b;
  logic [WORD_W-1:0] rd_data_a, rd_data_b;
  logic wr_valid, wr_ready, done;
  logic [AW-1:0] wr_addr, wr_idx;
  logic [31:0] wr_dist;

  always #2 clk = ~clk;

  logic [WORD_W-1:0] mem [NMAX];
  always_ff @(posedge clk) begin
    rd_data_a <= mem[rd_addr_a];
    rd_data_b <= mem[rd_addr_b];
  end

  mp_diag_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_m(cfg_m), .cfg_n(cfg_n),
    .diag_first(diag_first), .diag_last(diag_last),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_dist(wr_dist), .wr_idx(wr_idx), .done(done)
  );

  typedef struct { int a; int x; longint d; bit first; } exp_t;
  exp_t exp_q[$];
  int n_cmp = 0, n_bad = 0, got_wr = 0, done_cnt = 0;
  bit rand_ready = 0;

  task automatic chk(bit ok, string tag, string what, longint act, longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  function automatic int smp(int a);  return int'(signed'(mem[a][23:16])); endfunction
  function automatic int mu(int a);   return int'(signed'(mem[a][15:8]));  endfunction
  function automatic int sg(int a);   return int'(mem[a][7:0]);            endfunction

  task automatic fill(int seed);
    void'($urandom(seed));
    for (int a = 0; a < NMAX; a++) begin
      int s, u, v;
      s = int'($urandom_range(120)) - 60;
      u = int'($urandom_range(40)) - 20;
      v = int'($urandom_range(39)) + 1;
      mem[a] = {8'(s), 8'(u), 8'(v)};
    end
  endtask

  // Behavioural model: every dot product recomputed from scratch.
  task automatic model(int m, int n, int first, int last);
    longint prof [NMAX];
    int ns, thr;
    ns  = n - m + 1;
    thr = (m / 4 == 0) ? 1 : m / 4;
    for (int e = 0; e < NMAX; e++) prof[e] = 64'hFFFF_FFFF;
    for (int k = first; k <= last; k++) begin
      if (k < thr || k >= ns) continue;
      for (int i = 0; i < ns - k; i++) begin
        longint qt, diff, corr, d;
        int j;
        j = i + k;
        qt = 0;
        for (int t = 0; t < m; t++) qt += longint'(smp(i + t)) * smp(j + t);
        diff = qt - longint'(m) * mu(i) * mu(j);
        corr = (diff * sg(i) * sg(j)) >>> 8;
        d = 2 * ((longint'(m) <<< 8) - corr);
        if (d < 0) d = 0;
        if (d > 64'hFFFF_FFFF) d = 64'hFFFF_FFFF;
        if (d < prof[i]) begin prof[i] = d; exp_q.push_back('{i, j, d, i == 0}); end
        if (d < prof[j]) begin prof[j] = d; exp_q.push_back('{j, i, d, i == 0}); end
      end
    end
  endtask

  // Monitor: drive ready, then sample the word that the next edge transfers.
  bit prev_stall = 0;
  logic [AW-1:0] p_a, p_x;
  logic [31:0] p_d;
  always @(negedge clk) begin
    if (rst_n) begin
      wr_ready = rand_ready ? 1'($urandom_range(1)) : 1'b1;
      #1;
      if (prev_stall) begin
        chk(wr_valid && wr_addr == p_a && wr_idx == p_x && wr_dist == p_d,
            "R8", "stalled word held", longint'(wr_dist), longint'(p_d));
      end
      prev_stall = wr_valid && !wr_ready;
      p_a = wr_addr; p_x = wr_idx; p_d = wr_dist;
      if (wr_valid && wr_ready) begin
        got_wr++;
        if (exp_q.size() == 0) chk(0, "R4", "unexpected write", longint'(wr_addr), -1);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(int'(wr_addr) == e.a, "R4 R7", "write entry", longint'(wr_addr), e.a);
          chk(int'(wr_idx) == e.x, "R4 R7", "match index", longint'(wr_idx), e.x);
          chk(longint'(wr_dist) == e.d, e.first ? "R2" : "R3", "distance",
              longint'(wr_dist), e.d);
        end
      end
      if (done) begin
        done_cnt++;
        chk(exp_q.size() == 0, "R9", "writes left at done", exp_q.size(), 0);
      end
    end
  end

  task automatic run(int m, int n, int first, int last, bit poke, string tag);
    int want, cyc, d0;
    exp_q.delete();
    model(m, n, first, last);
    want = exp_q.size();
    got_wr = 0;
    d0 = done_cnt;
    @(negedge clk);
    start = 1; cfg_m = CW'(m); cfg_n = CW'(n);
    diag_first = CW'(first); diag_last = CW'(last);
    @(negedge clk);
    start = 0;
    cyc = 0;
    while (done_cnt == d0 && cyc < 40000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 40) begin
        start = 1; cfg_m = 6'd4; cfg_n = 6'd30; diag_first = 0; diag_last = 6'd25;
      end else start = 0;
    end
    chk(cyc < 40000, "R9", "watchdog, done seen", cyc, 0);
    repeat (3) @(negedge clk);
    chk(done_cnt == d0 + 1, "R9", "single done pulse", done_cnt - d0, 1);
    chk(got_wr == want, tag, "write count", got_wr, want);
  endtask

  initial begin
    wr_ready = 1'b1;
    fill(11);
    repeat (3) @(negedge clk);
    chk(wr_valid == 1'b0, "R1", "wr_valid in reset", wr_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wr_valid == 1'b0 && done == 1'b0, "R1", "idle outputs", {wr_valid, done}, 0);

    run(4, 16, 1, 12, 0, "R2 R3");
    rand_ready = 1;
    run(8, 24, 0, 20, 0, "R6 R7");
    run(8, 20, 0, 1, 0, "R6");
    fill(77);
    run(3, 12, 2, 20, 1, "R9");
    run(4, 16, 1, 12, 0, "R5");
    run(4, 16, 1, 12, 0, "R5");
    rand_ready = 0;
    run(12, 32, 3, 18, 0, "R3 R4");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule